// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns logical addresses issued by a processor into physical addresses for the low memory region. It holds a table of 1024 sixteen-bit page entries. A translate request indexes the table with the logical page number and returns the physical page number joined to the unchanged page offset. Addresses above the translated region come back exactly as they were presented. Each translated access also records its own use in the entry it touched. A read marks the page accessed. A write marks it accessed and dirty. Neither mark is made when the entry's status field is zero, which means the page is absent.

Software builds and inspects the table through a byte-wide port that treats the table as 2 KB of ordinary memory. This port can run in the same cycle as a translation. Both the translation and a port read see the table as it was before that cycle's writes. A port write to an entry's status byte overrides a status update to the same byte in the same cycle. The table itself has no reset and must be written through the port before it is used.

Top module: `pgx_xlate`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rsp_valid` is 0, `rsp_addr` is 0 and `bus_rdata` is 0.
- R2: `rsp_valid` is high in the cycle after each cycle with `xl_valid` high and low otherwise, and `rsp_addr` carries that request's result in that same cycle.
- R3: An address with bits 23:22 both zero (below 0x400000) is translated. Bits 21:12 select entry n. The result is two zero bits, then entry bits 9:0, then address bits 11:0.
- R4: Any other address is returned unchanged and alters no entry.
- R5: A translated write (`xl_write`=1) to an entry whose status field (bits 14:13) is nonzero sets both bits 14 and 13.
- R6: A translated read (`xl_write`=0) to an entry whose status field is nonzero sets bit 14 and leaves bit 13 as it was.
- R7: A translated access to an entry whose status field is 00 changes no bit of that entry.
- R8: Entry n is stored as two bytes. Bits 15:8 are at port byte address 2n and bits 7:0 are at 2n+1. A port write (`bus_en`=1, `bus_we`=1) stores `bus_wdata` there. A port read (`bus_en`=1, `bus_we`=0) presents the byte on `bus_rdata` in the next cycle.
- R9: When a port write to byte 2n and a status update of entry n fall in the same cycle, the port data is what entry n's high byte holds afterwards.
- R10: A translation and a port read issued in the same cycle both use the table contents from before that cycle's writes.
- R11: `bus_rdata` keeps its value in every cycle that follows a cycle without a port read.
- R12: A status update leaves bit 15, bits 12:0 and the whole low byte of the entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_valid | input | 1 | Translate request strobe |
| xl_write | input | 1 | 1 = request is a write access, 0 = read access |
| xl_addr | input | 24 | Logical address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 24 | Physical (or passed-through) address |
| bus_en | input | 1 | Table port access strobe |
| bus_we | input | 1 | Table port write select |
| bus_addr | input | 11 | Table port byte address |
| bus_wdata | input | 8 | Table port write byte |
| bus_rdata | output | 8 | Table port read byte, registered |

## Verification
The checker assumes that `xl_valid`, `xl_addr`, `bus_en` and `bus_we` are driven to known levels in every cycle after reset. Its response properties relate only the address fields to the request that came one cycle earlier. The bench meets this by driving every input between clock edges from a single task, and it writes all 2048 table bytes before the first translation so that no lookup reads uninitialised storage. The random traffic keeps the pages it uses mostly within a small set. This makes translations, status updates and port accesses to the same entry collide often, and the directed cases then pin the region boundary and the same-cycle precedence.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ADDR_W      = 24; // logical/physical address width
  localparam int OFS_W       = 12; // page offset width
  localparam int IDX_W       = 10; // log2 of table entries
  localparam int PFN_W       = 10; // physical page number width in an entry
  localparam int ST_ACC_BIT  = 14; // accessed flag position in an entry
  localparam int ST_DRT_BIT  = 13; // dirty flag position in an entry

  typedef enum logic {
    ACC_RD = 1'b0,
    ACC_WR = 1'b1
  } acc_e;
endpackage

// File: rtl/pgx_store.sv
// Page table storage: two byte lanes (high byte at even address), an
// asynchronous lookup port, a status write port on the high lane and a
// byte-wide registered access port.
module pgx_store #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] tr_idx,
  output logic [7:0]       tr_hi,
  output logic [7:0]       tr_lo,
  input  logic             st_we,
  input  logic [IDX_W-1:0] st_idx,
  input  logic [7:0]       st_hi,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [IDX_W:0]   bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata
);
  localparam int NENT = 1 << IDX_W;

  logic [7:0]       lane_rd [2];
  logic [7:0]       lane_q  [2];
  logic [IDX_W-1:0] bus_idx;
  logic             sel_q;

  assign bus_idx = bus_addr[IDX_W:1];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam logic LANE = 1'(g);
    logic [7:0] mem [NENT];

    always_ff @(posedge clk) begin
      if (g == 0 && st_we)
        mem[st_idx] <= st_hi;
      // written after the status update so a port write to the same byte wins
      if (bus_wr && bus_addr[0] == LANE)
        mem[bus_idx] <= bus_wdata;
    end

    assign lane_rd[g] = mem[tr_idx];

    always_ff @(posedge clk) begin
      if (rst)         lane_q[g] <= '0;
      else if (bus_rd) lane_q[g] <= mem[bus_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (bus_rd) sel_q <= bus_addr[0];
  end

  assign tr_hi     = lane_rd[0];
  assign tr_lo     = lane_rd[1];
  assign bus_rdata = sel_q ? lane_q[1] : lane_q[0];
endmodule

// File: rtl/pgx_lookup.sv
// Combinational translation: region test, address splice and the new
// high byte of the entry after the use marks are applied.
module pgx_lookup
  import pgx_pkg::*;
#(
  parameter int A_W   = ADDR_W,
  parameter int O_W   = OFS_W,
  parameter int I_W   = IDX_W,
  parameter int P_W   = PFN_W,
  parameter int ACC_B = ST_ACC_BIT,
  parameter int DRT_B = ST_DRT_BIT
) (
  input  logic           xl_valid,
  input  acc_e           xl_kind,
  input  logic [A_W-1:0] xl_addr,
  input  logic [7:0]     ent_hi,
  input  logic [7:0]     ent_lo,
  output logic [I_W-1:0] idx,
  output logic [A_W-1:0] phys,
  output logic           st_we,
  output logic [7:0]     st_hi
);
  localparam int REG_LSB = O_W + I_W;
  localparam int PAD_W   = A_W - O_W - P_W;
  localparam int ACC_HB  = ACC_B - 8;
  localparam int DRT_HB  = DRT_B - 8;

  logic [15:0] entry;
  logic        in_region;
  logic [7:0]  set_mask;

  assign entry     = {ent_hi, ent_lo};
  assign idx       = xl_addr[REG_LSB-1:O_W];
  assign in_region = (xl_addr[A_W-1:REG_LSB] == '0);

  always_comb begin
    if (in_region)
      phys = {{PAD_W{1'b0}}, entry[P_W-1:0], xl_addr[O_W-1:0]};
    else
      phys = xl_addr;
  end

  always_comb begin
    set_mask         = '0;
    set_mask[ACC_HB] = 1'b1;
    if (xl_kind == ACC_WR)
      set_mask[DRT_HB] = 1'b1;
  end

  assign st_we = xl_valid && in_region && (entry[ACC_B] || entry[DRT_B]);
  assign st_hi = ent_hi | set_mask;
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int I_W = IDX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           xl_valid,
  input  logic           xl_write,
  input  logic [A_W-1:0] xl_addr,
  output logic           rsp_valid,
  output logic [A_W-1:0] rsp_addr,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [I_W:0]   bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata
);
  logic [I_W-1:0] idx;
  logic [7:0]     ent_hi, ent_lo, st_hi;
  logic [A_W-1:0] phys;
  logic           st_we;
  acc_e           kind;

  assign kind = xl_write ? ACC_WR : ACC_RD;

  pgx_store #(.IDX_W(I_W)) u_store (
    .clk(clk), .rst(rst),
    .tr_idx(idx), .tr_hi(ent_hi), .tr_lo(ent_lo),
    .st_we(st_we), .st_idx(idx), .st_hi(st_hi),
    .bus_rd(bus_en && !bus_we), .bus_wr(bus_en && bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  pgx_lookup #(.A_W(A_W), .I_W(I_W)) u_lookup (
    .xl_valid(xl_valid), .xl_kind(kind), .xl_addr(xl_addr),
    .ent_hi(ent_hi), .ent_lo(ent_lo),
    .idx(idx), .phys(phys), .st_we(st_we), .st_hi(st_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= xl_valid;
      if (xl_valid) rsp_addr <= phys;
    end
  end
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
  parameter int A_W     = 24,
  parameter int REG_LSB = 22,
  parameter int O_W     = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           xl_valid,
  input logic [A_W-1:0] xl_addr,
  input logic           rsp_valid,
  input logic [A_W-1:0] rsp_addr,
  input logic           bus_en,
  input logic           bus_we,
  input logic [7:0]     bus_rdata
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |=> !rsp_valid);

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> rsp_addr[O_W-1:0] == $past(xl_addr[O_W-1:0]));

  p_high_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_addr[A_W-1:REG_LSB] == '0) |=> rsp_addr[A_W-1:REG_LSB] == '0);

  p_passthru_r4: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_addr[A_W-1:REG_LSB] != '0) |=> rsp_addr == $past(xl_addr));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata));
endmodule

bind pgx_xlate pgx_xlate_chk #(
  .A_W(A_W), .REG_LSB(pgx_pkg::OFS_W + I_W), .O_W(pgx_pkg::OFS_W)
) u_chk (
  .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_addr(xl_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .bus_en(bus_en), .bus_we(bus_we), .bus_rdata(bus_rdata)
);

// File: tb/pgx_xlate_tb.sv
`timescale 1ns/1ps
module pgx_xlate_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xl_valid = 1'b0, xl_write = 1'b0;
  logic [23:0] xl_addr = '0;
  logic        rsp_valid;
  logic [23:0] rsp_addr;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] shadow [0:2047];
  logic        e_rv;
  logic [23:0] e_ra;
  logic [7:0]  e_rd = 8'h00;
  logic        e_was_rd;

  always #2 clk = ~clk;

  pgx_xlate u_dut (
    .clk(clk), .rst(rst), .xl_valid(xl_valid), .xl_write(xl_write),
    .xl_addr(xl_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (act !== exv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exv);
    end
  endtask

  function automatic logic [23:0] model_phys(input logic [23:0] a);
    logic [15:0] ent;
    if (a[23:22] != 2'b00) return a;
    ent = {shadow[{a[21:12], 1'b0}], shadow[{a[21:12], 1'b1}]};
    return {2'b00, ent[9:0], a[11:0]};
  endfunction

  // one cycle: drive at negedge, update model, check at next negedge
  task automatic step(input logic xv, input logic xw, input logic [23:0] xa,
                      input logic be, input logic bw, input logic [10:0] ba,
                      input logic [7:0] bd);
    logic [10:0] hb;
    xl_valid = xv; xl_write = xw; xl_addr = xa;
    bus_en = be; bus_we = bw; bus_addr = ba; bus_wdata = bd;
    e_rv = xv;
    if (xv) e_ra = model_phys(xa);
    e_was_rd = be && !bw;
    if (e_was_rd) e_rd = shadow[ba];
    hb = {xa[21:12], 1'b0};
    if (xv && xa[23:22] == 2'b00 && (shadow[hb][6] || shadow[hb][5]))
      shadow[hb] = shadow[hb] | (xw ? 8'h60 : 8'h40);
    if (be && bw) shadow[ba] = bd;
    @(posedge clk); @(negedge clk);
    chk("R2 rsp_valid", {31'b0, rsp_valid}, {31'b0, e_rv});
    if (e_rv) chk(xa[23:22] == 2'b00 ? "R3 rsp_addr" : "R4 rsp_addr", {8'b0, rsp_addr}, {8'b0, e_ra});
    chk(e_was_rd ? "R8 bus_rdata" : "R11 bus_rdata", {24'b0, bus_rdata}, {24'b0, e_rd});
    xl_valid = 1'b0; bus_en = 1'b0;
  endtask

  task automatic wr_byte(input logic [10:0] ba, input logic [7:0] d);
    step(1'b0, 1'b0, 24'h0, 1'b1, 1'b1, ba, d);
  endtask

  task automatic rd_expect(input logic [10:0] ba, input logic [7:0] exv, input string tag);
    step(1'b0, 1'b0, 24'h0, 1'b1, 1'b0, ba, 8'h00);
    chk(tag, {24'b0, bus_rdata}, {24'b0, exv});
  endtask

  task automatic xl(input logic w, input logic [23:0] a, input logic [23:0] exv, input string tag);
    step(1'b1, w, a, 1'b0, 1'b0, 11'h0, 8'h00);
    chk(tag, {8'b0, rsp_addr}, {8'b0, exv});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rsp_addr", {8'b0, rsp_addr}, 32'd0);
    chk("R1 bus_rdata", {24'b0, bus_rdata}, 32'd0);
    rst = 1'b0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) wr_byte(11'(i), 8'($urandom));

    // R6 / R12: read with status 01 sets bit 14, keeps bit 15 and 12:0
    wr_byte(11'd10, 8'hBD); wr_byte(11'd11, 8'h5A);
    xl(1'b0, 24'h005123, {2'b00, 10'h15A, 12'h123}, "R3 page 5 splice");
    rd_expect(11'd10, 8'hFD, "R6 read marks accessed");
    rd_expect(11'd11, 8'h5A, "R12 low byte kept");
    // R6: status 10, read leaves bit 13 clear
    wr_byte(11'd12, 8'hC1);
    xl(1'b0, 24'h006000, model_phys(24'h006000), "R3 page 6");
    rd_expect(11'd12, 8'hC1, "R6 bit13 untouched");
    // R5: write sets both
    wr_byte(11'd14, 8'h41);
    xl(1'b1, 24'h007FFF, model_phys(24'h007FFF), "R3 page 7");
    rd_expect(11'd14, 8'h61, "R5 write marks dirty");
    wr_byte(11'd16, 8'h22);
    xl(1'b1, 24'h008001, model_phys(24'h008001), "R3 page 8");
    rd_expect(11'd16, 8'h62, "R5 write from 01");
    // R7: absent page untouched
    wr_byte(11'd2046, 8'h9F); wr_byte(11'd2047, 8'h01);
    xl(1'b1, 24'h3FFFFF, {2'b00, 10'h301, 12'hFFF}, "R3 top page boundary");
    rd_expect(11'd2046, 8'h9F, "R7 absent page unchanged");
    // R4: just above region, entry 0 untouched
    wr_byte(11'd0, 8'h20);
    xl(1'b1, 24'h400000, 24'h400000, "R4 boundary pass-through");
    xl(1'b0, 24'hC00ABC, 24'hC00ABC, "R4 high pass-through");
    rd_expect(11'd0, 8'h20, "R4 no entry change");
    // R9 / R10: same-cycle port write wins, translation sees old entry
    wr_byte(11'd18, 8'h20); wr_byte(11'd19, 8'h77);
    step(1'b1, 1'b1, 24'h009444, 1'b1, 1'b1, 11'd18, 8'h03);
    chk("R10 old entry used", {8'b0, rsp_addr}, {8'b0, 2'b00, 10'h077, 12'h444});
    rd_expect(11'd18, 8'h03, "R9 port write wins");
    // R10: port read of the byte being marked returns old value
    wr_byte(11'd20, 8'h20);
    step(1'b1, 1'b0, 24'h00A000, 1'b1, 1'b0, 11'd20, 8'h00);
    chk("R10 read before update", {24'b0, bus_rdata}, 32'h20);
    rd_expect(11'd20, 8'h60, "R6 update after");

    // random traffic over a small page set
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] a;
      logic [10:0] ba;
      a = 24'($urandom);
      if ($urandom_range(3) != 0) a[23:16] = 8'h00;
      if ($urandom_range(1) == 0) a[21:12] = 10'($urandom_range(7));
      ba = 11'($urandom);
      if ($urandom_range(1) == 0) ba = 11'($urandom_range(15));
      step(1'($urandom), 1'($urandom), a, 1'($urandom), 1'($urandom), ba, 8'($urandom));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule